// File: doc/BRIEF.md
# Retirement Program-Counter Chain Monitor

This monitor sits beside a processor core and listens to its retirement trace. Every retired instruction shows up on one of several parallel channels. Each one carries an order index that rises by one per instruction in program order, the address it was fetched from, and the address of the instruction that should run after it. The monitor checks that, for every two instructions adjacent in program order, the later one's fetch address equals the earlier one's next address. A break anywhere in that chain is flagged.

The two halves of a pair may retire in either order, in the same cycle or in different cycles. A small table indexed by the low bits of the order index keeps recent retirements. Each pair is checked once, by whichever half arrives second. If the later half arrives second, it looks back to its predecessor. If the earlier half arrives second, it looks forward to its successor. Halves that arrive in the same cycle are compared directly across channels. The logic is plain synthesizable RTL, so it can run next to the core in simulation, in emulation or on an FPGA. The first mismatch raises a sticky flag and freezes a record of the failing pair.

Top module: `retire_chain_mon`

## Requirements
- R1: While rst_ni is low, and after it is released with no retirement yet, err_o is 0 and err_ord_o, err_exp_pc_o and err_act_pc_o are all 0.
- R2: Backward check: when order n retires and order n-1 retired in an earlier cycle, a fetch address of n that differs from the next address of n-1 raises err_o.
- R3: Forward check: when order n retires and order n+1 retired in an earlier cycle, a next address of n that differs from the fetch address of n+1 raises err_o.
- R4: When orders n and n+1 retire in the same cycle on different channels, the pair is compared and a mismatch raises err_o.
- R5: A retirement whose neighbours in order have not been seen, including the first retirement after reset, is never flagged, and a chain whose addresses all link correctly never raises err_o.
- R6: A channel whose valid bit is 0 is ignored: its fields are not checked and are not stored for later checks.
- R7: Once set, err_o stays at 1 and the record stays unchanged until reset, whatever retires afterwards.
- R8: The record holds the order index of the later instruction of the failing pair (err_ord_o), the earlier instruction's next address (err_exp_pc_o) and the later instruction's fetch address (err_act_pc_o).
- R9: err_o and the record update at the clock edge that samples the failing retirement.
- R10: If several pairs fail in one cycle, the lowest-numbered channel wins, and within a channel a backward failure wins over a forward one.
- R11: The table matches entries by the full order index, so an entry left by order m is never used as the neighbour of an order that only shares m's low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ret_vld_i | input | NCH | Per-channel retirement valid |
| ret_ord_i | input | NCH*OW | Order index per channel, channel c at bits [c*OW +: OW] |
| ret_pc_i | input | NCH*AW | Fetch address per channel, channel c at bits [c*AW +: AW] |
| ret_npc_i | input | NCH*AW | Next-instruction address per channel, channel c at bits [c*AW +: AW] |
| err_o | output | 1 | Sticky chain-break flag |
| err_ord_o | output | OW | Order index of the later instruction of the first failing pair |
| err_exp_pc_o | output | AW | Next address reported by the earlier instruction of that pair |
| err_act_pc_o | output | AW | Fetch address reported by the later instruction of that pair |

## Verification
Directed cases each isolate one way a pair can come together: predecessor first, successor first, both halves in one cycle, a garbage-carrying invalid channel, a stale table slot that shares low bits, and two failures in one cycle on different channels. Together they separate the backward, forward and cross-channel paths, the tag compare and the priority order. Random episodes build programs with sequential steps and jumps and sometimes corrupt one fetch address. They then retire the instructions shuffled within small windows, two channels at a time, with idle gaps. A bench model decides when err_o must rise and what the record must hold, so both correct chains and a break at any position and arrival order are covered.

// File: rtl/rcm_pkg.sv
package rcm_pkg;
  typedef enum logic [1:0] {
    FK_NONE = 2'd0,
    FK_BWD  = 2'd1,
    FK_FWD  = 2'd2
  } fail_kind_e;
endpackage

// File: rtl/rcm_table.sv
module rcm_table #(
  parameter int NCH   = 2,
  parameter int AW    = 32,
  parameter int OW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_i  [NCH],
  input  logic [OW-1:0] ord_i  [NCH],
  input  logic [AW-1:0] pc_i   [NCH],
  input  logic [AW-1:0] npc_i  [NCH],
  output logic          prev_hit_o [NCH],
  output logic [AW-1:0] prev_npc_o [NCH],
  output logic          next_hit_o [NCH],
  output logic [AW-1:0] next_pc_o  [NCH]
);
  // DEPTH must be a power of two
  localparam int IW = $clog2(DEPTH);

  logic [DEPTH-1:0] slot_vld;
  logic [OW-1:0]    slot_tag [DEPTH];
  logic [AW-1:0]    slot_pc  [DEPTH];
  logic [AW-1:0]    slot_npc [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_vld <= '0;
    end else begin
      for (int c = 0; c < NCH; c++)
        if (vld_i[c]) slot_vld[ord_i[c][IW-1:0]] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    for (int c = 0; c < NCH; c++) begin
      if (vld_i[c]) begin
        slot_tag[ord_i[c][IW-1:0]] <= ord_i[c];
        slot_pc [ord_i[c][IW-1:0]] <= pc_i[c];
        slot_npc[ord_i[c][IW-1:0]] <= npc_i[c];
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_lk
    logic [OW-1:0] pord, nord;
    assign pord = ord_i[c] - OW'(1);
    assign nord = ord_i[c] + OW'(1);
    assign prev_hit_o[c] = slot_vld[pord[IW-1:0]] && (slot_tag[pord[IW-1:0]] == pord);
    assign prev_npc_o[c] = slot_npc[pord[IW-1:0]];
    assign next_hit_o[c] = slot_vld[nord[IW-1:0]] && (slot_tag[nord[IW-1:0]] == nord);
    assign next_pc_o[c]  = slot_pc[nord[IW-1:0]];
  end
endmodule

// File: rtl/rcm_lane.sv
module rcm_lane #(
  parameter int NCH  = 2,
  parameter int AW   = 32,
  parameter int OW   = 16,
  parameter int LANE = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_i [NCH],
  input  logic [OW-1:0] ord_i [NCH],
  input  logic [AW-1:0] pc_i  [NCH],
  input  logic [AW-1:0] npc_i [NCH],
  input  logic          prev_hit_i,
  input  logic [AW-1:0] prev_npc_i,
  input  logic          next_hit_i,
  input  logic [AW-1:0] next_pc_i,
  output logic          fail_o,
  output logic [OW-1:0] fail_ord_o,
  output logic [AW-1:0] fail_exp_o,
  output logic [AW-1:0] fail_act_o
);
  import rcm_pkg::*;

  logic [OW-1:0] pord;
  logic          same_hit;
  logic [AW-1:0] same_npc;
  logic          have_pred;
  logic [AW-1:0] pred_npc;
  fail_kind_e    kind;

  assign pord = ord_i[LANE] - OW'(1);

  // predecessor retiring in the same cycle on another channel
  always_comb begin
    same_hit = 1'b0;
    same_npc = '0;
    for (int j = 0; j < NCH; j++) begin
      if (j != LANE && vld_i[j] && ord_i[j] == pord) begin
        same_hit = 1'b1;
        same_npc = npc_i[j];
      end
    end
  end

  assign have_pred = same_hit || prev_hit_i;
  assign pred_npc  = same_hit ? same_npc : prev_npc_i;

  always_comb begin
    kind = FK_NONE;
    if (vld_i[LANE]) begin
      if (have_pred && pred_npc != pc_i[LANE])            kind = FK_BWD;
      else if (next_hit_i && next_pc_i != npc_i[LANE])    kind = FK_FWD;
    end
  end

  always_comb begin
    fail_o     = (kind != FK_NONE);
    fail_ord_o = '0;
    fail_exp_o = '0;
    fail_act_o = '0;
    if (kind == FK_BWD) begin
      fail_ord_o = ord_i[LANE];
      fail_exp_o = pred_npc;
      fail_act_o = pc_i[LANE];
    end else if (kind == FK_FWD) begin
      fail_ord_o = ord_i[LANE] + OW'(1);
      fail_exp_o = npc_i[LANE];
      fail_act_o = next_pc_i;
    end
  end

  AST_INVALID_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i[LANE] |-> !fail_o); // R6
endmodule

// File: rtl/rcm_err_latch.sv
module rcm_err_latch #(
  parameter int NCH = 2,
  parameter int AW  = 32,
  parameter int OW  = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fail_i     [NCH],
  input  logic [OW-1:0] fail_ord_i [NCH],
  input  logic [AW-1:0] fail_exp_i [NCH],
  input  logic [AW-1:0] fail_act_i [NCH],
  output logic          err_o,
  output logic [OW-1:0] err_ord_o,
  output logic [AW-1:0] err_exp_pc_o,
  output logic [AW-1:0] err_act_pc_o
);
  logic          any_fail;
  logic [OW-1:0] sel_ord;
  logic [AW-1:0] sel_exp, sel_act;

  // lowest channel wins
  always_comb begin
    any_fail = 1'b0;
    sel_ord  = '0;
    sel_exp  = '0;
    sel_act  = '0;
    for (int c = NCH-1; c >= 0; c--) begin
      if (fail_i[c]) begin
        any_fail = 1'b1;
        sel_ord  = fail_ord_i[c];
        sel_exp  = fail_exp_i[c];
        sel_act  = fail_act_i[c];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o        <= 1'b0;
      err_ord_o    <= '0;
      err_exp_pc_o <= '0;
      err_act_pc_o <= '0;
    end else if (!err_o && any_fail) begin
      err_o        <= 1'b1;
      err_ord_o    <= sel_ord;
      err_exp_pc_o <= sel_exp;
      err_act_pc_o <= sel_act;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R7
  AST_REC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> ($stable(err_ord_o) && $stable(err_exp_pc_o) && $stable(err_act_pc_o))); // R7
  AST_REC_DIFFERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (err_exp_pc_o != err_act_pc_o)); // R8
  AST_RISE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(any_fail)); // R9
endmodule

// File: rtl/retire_chain_mon.sv
module retire_chain_mon #(
  parameter int NCH   = 2,
  parameter int AW    = 32,
  parameter int OW    = 16,
  parameter int DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH-1:0]    ret_vld_i,
  input  logic [NCH*OW-1:0] ret_ord_i,
  input  logic [NCH*AW-1:0] ret_pc_i,
  input  logic [NCH*AW-1:0] ret_npc_i,
  output logic              err_o,
  output logic [OW-1:0]     err_ord_o,
  output logic [AW-1:0]     err_exp_pc_o,
  output logic [AW-1:0]     err_act_pc_o
);
  logic          vld  [NCH];
  logic [OW-1:0] ord  [NCH];
  logic [AW-1:0] pc   [NCH];
  logic [AW-1:0] npc  [NCH];
  logic          prev_hit [NCH];
  logic [AW-1:0] prev_npc [NCH];
  logic          next_hit [NCH];
  logic [AW-1:0] next_pc  [NCH];
  logic          fail     [NCH];
  logic [OW-1:0] fail_ord [NCH];
  logic [AW-1:0] fail_exp [NCH];
  logic [AW-1:0] fail_act [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign vld[c] = ret_vld_i[c];
    assign ord[c] = ret_ord_i[c*OW +: OW];
    assign pc[c]  = ret_pc_i[c*AW +: AW];
    assign npc[c] = ret_npc_i[c*AW +: AW];

    rcm_lane #(.NCH(NCH), .AW(AW), .OW(OW), .LANE(c)) u_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .vld_i      (vld),
      .ord_i      (ord),
      .pc_i       (pc),
      .npc_i      (npc),
      .prev_hit_i (prev_hit[c]),
      .prev_npc_i (prev_npc[c]),
      .next_hit_i (next_hit[c]),
      .next_pc_i  (next_pc[c]),
      .fail_o     (fail[c]),
      .fail_ord_o (fail_ord[c]),
      .fail_exp_o (fail_exp[c]),
      .fail_act_o (fail_act[c])
    );
  end

  rcm_table #(.NCH(NCH), .AW(AW), .OW(OW), .DEPTH(DEPTH)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vld_i      (vld),
    .ord_i      (ord),
    .pc_i       (pc),
    .npc_i      (npc),
    .prev_hit_o (prev_hit),
    .prev_npc_o (prev_npc),
    .next_hit_o (next_hit),
    .next_pc_o  (next_pc)
  );

  rcm_err_latch #(.NCH(NCH), .AW(AW), .OW(OW)) u_err (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fail_i       (fail),
    .fail_ord_i   (fail_ord),
    .fail_exp_i   (fail_exp),
    .fail_act_i   (fail_act),
    .err_o        (err_o),
    .err_ord_o    (err_ord_o),
    .err_exp_pc_o (err_exp_pc_o),
    .err_act_pc_o (err_act_pc_o)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rst_ni) |-> !err_o); // R1
endmodule

// File: tb/retire_chain_mon_tb.sv
module retire_chain_mon_tb;
  localparam int NCH = 2;
  localparam int AW  = 32;
  localparam int OW  = 16;
  localparam int MAXO = 1024;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH-1:0]    vld = '0;
  logic [NCH*OW-1:0] ord = '0;
  logic [NCH*AW-1:0] pc = '0;
  logic [NCH*AW-1:0] npc = '0;
  logic              err;
  logic [OW-1:0]     err_ord;
  logic [AW-1:0]     err_exp, err_act;

  int n_run = 0, n_fail = 0;

  // model state
  bit          m_seen [MAXO];
  logic [AW-1:0] m_pc [MAXO];
  logic [AW-1:0] m_npc [MAXO];
  bit          x_err;
  logic [OW-1:0] x_ord;
  logic [AW-1:0] x_exp, x_act;

  // program for random episodes
  logic [AW-1:0] p_pc [64];
  logic [AW-1:0] p_npc [64];
  int          perm [4];

  always #10 clk = ~clk;  // 50 MHz

  retire_chain_mon #(.NCH(NCH), .AW(AW), .OW(OW), .DEPTH(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ret_vld_i(vld), .ret_ord_i(ord),
    .ret_pc_i(pc), .ret_npc_i(npc), .err_o(err), .err_ord_o(err_ord),
    .err_exp_pc_o(err_exp), .err_act_pc_o(err_act));

  initial begin
    #4_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " err"}, AW'(err), AW'(x_err));
    chk({req, " ord"}, AW'(err_ord), AW'(x_ord));
    chk({req, " exp"}, err_exp, x_exp);
    chk({req, " act"}, err_act, x_act);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; vld = '0;
    for (int i = 0; i < MAXO; i++) m_seen[i] = 1'b0;
    x_err = 0; x_ord = '0; x_exp = '0; x_act = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // model of the requirements for one cycle of retirements
  task automatic model(input bit v [NCH], input int o [NCH],
                       input logic [AW-1:0] a [NCH], input logic [AW-1:0] b [NCH]);
    for (int c = 0; c < NCH; c++) begin
      bit found = 0, hp = 0;
      logic [AW-1:0] pn = '0;
      if (!v[c] || x_err) continue;
      for (int j = 0; j < NCH; j++)
        if (j != c && v[j] && o[j] == o[c]-1) begin hp = 1; pn = b[j]; end
      if (!hp && o[c] > 0 && m_seen[o[c]-1]) begin hp = 1; pn = m_npc[o[c]-1]; end
      if (hp && pn != a[c]) begin
        found = 1; x_ord = OW'(o[c]); x_exp = pn; x_act = a[c];
      end else if (m_seen[o[c]+1] && m_pc[o[c]+1] != b[c]) begin
        found = 1; x_ord = OW'(o[c]+1); x_exp = b[c]; x_act = m_pc[o[c]+1];
      end
      if (found) x_err = 1;
    end
    for (int c = 0; c < NCH; c++)
      if (v[c]) begin m_seen[o[c]] = 1; m_pc[o[c]] = a[c]; m_npc[o[c]] = b[c]; end
  endtask

  // drive one cycle at negedge, return after the sampling edge
  task automatic step(input bit v0, input int o0, input logic [AW-1:0] a0, input logic [AW-1:0] b0,
                      input bit v1, input int o1, input logic [AW-1:0] a1, input logic [AW-1:0] b1);
    bit v [NCH];
    int o [NCH];
    logic [AW-1:0] a [NCH];
    logic [AW-1:0] b [NCH];
    v[0] = v0; o[0] = o0; a[0] = a0; b[0] = b0;
    v[1] = v1; o[1] = o1; a[1] = a1; b[1] = b1;
    vld = {v1, v0};
    ord = {OW'(o1), OW'(o0)};
    pc  = {a1, a0};
    npc = {b1, b0};
    model(v, o, a, b);
    @(negedge clk);
    vld = '0;
  endtask

  task automatic one(input int o, input logic [AW-1:0] a, input logic [AW-1:0] b);
    step(1, o, a, b, 0, 0, 32'hdead_beef, 32'hdead_beef);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1 reset state
    @(negedge clk);
    chk("R1 err in reset", AW'(err), '0);
    chk("R1 ord in reset", AW'(err_ord), '0);
    do_reset();
    chk_all("R1 after release");

    // R5 first retirement and correct in-order chain
    for (int i = 0; i < 10; i++) one(i, 32'h1000 + 4*i, 32'h1004 + 4*i);
    chk("R5 clean chain err", AW'(err), '0);
    chk_all("R5 model");

    // R2 R8 R9 backward mismatch
    do_reset();
    one(0, 32'h100, 32'h104);
    one(1, 32'h200, 32'h204);
    chk("R9 err at sampling edge", AW'(err), 1);
    chk("R8 ord", AW'(err_ord), 1);
    chk("R8 exp", err_exp, 32'h104);
    chk("R2 act", err_act, 32'h200);

    // R3 forward mismatch: successor first
    do_reset();
    one(1, 32'h200, 32'h204);
    chk("R5 lone retirement", AW'(err), '0);
    one(0, 32'h100, 32'h104);
    chk("R3 err", AW'(err), 1);
    chk("R3 ord", AW'(err_ord), 1);
    chk("R3 exp", err_exp, 32'h104);
    chk("R3 act", err_act, 32'h200);

    // R4 same-cycle pair, later on channel 0
    do_reset();
    step(1, 1, 32'h300, 32'h304, 1, 0, 32'h100, 32'h104);
    chk("R4 err", AW'(err), 1);
    chk("R4 act", err_act, 32'h300);
    chk("R4 exp", err_exp, 32'h104);
    do_reset();
    step(1, 0, 32'h100, 32'h104, 1, 1, 32'h104, 32'h108);
    chk("R4 linked pair", AW'(err), '0);

    // R6 invalid channel ignored
    do_reset();
    one(0, 32'h100, 32'h104);
    step(1, 5, 32'h900, 32'h904, 0, 1, 32'h999, 32'h500);
    chk("R6 invalid unchecked", AW'(err), '0);
    one(2, 32'h600, 32'h604);
    chk("R6 invalid not stored", AW'(err), '0);
    one(1, 32'h104, 32'h600);
    chk("R6 real order linked", AW'(err), '0);
    chk_all("R6 model");

    // R7 sticky and first record held
    do_reset();
    one(0, 32'h100, 32'h104);
    one(1, 32'h110, 32'h114);
    one(2, 32'h220, 32'h224);
    repeat (3) @(negedge clk);
    chk("R7 err held", AW'(err), 1);
    chk("R7 ord held", AW'(err_ord), 1);
    chk("R7 act held", err_act, 32'h110);

    // R10 priority across channels
    do_reset();
    one(4, 32'h40, 32'h44);
    one(7, 32'h70, 32'h74);
    step(1, 8, 32'h800, 32'h804, 1, 5, 32'h500, 32'h504);
    chk("R10 ord chan0", AW'(err_ord), 8);
    chk("R10 act chan0", err_act, 32'h800);
    // R10 backward over forward in one lane
    do_reset();
    one(2, 32'h20, 32'h24);
    one(4, 32'h40, 32'h44);
    one(3, 32'h30, 32'h34);
    chk("R10 bwd first ord", AW'(err_ord), 3);
    chk("R10 bwd first act", err_act, 32'h30);

    // R11 stale slot sharing low bits
    do_reset();
    one(0, 32'h100, 32'h104);
    one(9, 32'hABC0, 32'hABC4);
    chk("R11 stale tag unused", AW'(err), '0);
    one(7, 32'h70, 32'h1234);
    chk("R11 stale fwd unused", AW'(err), '0);

    // random episodes
    for (int ep = 0; ep < 40; ep++) begin
      int bad;
      do_reset();
      p_pc[0] = {$urandom_range(0, 32'hFFFF), 2'b00};
      for (int k = 0; k < 64; k++) begin
        if (k > 0) p_pc[k] = p_npc[k-1];
        p_npc[k] = ($urandom_range(0, 3) == 0) ? {$urandom_range(0, 32'hFFFF), 2'b00}
                                               : p_pc[k] + 4;
      end
      bad = ($urandom_range(0, 1) == 1) ? int'($urandom_range(1, 63)) : -1;
      if (bad >= 0) p_pc[bad] = p_pc[bad] ^ 32'h10;
      for (int blk = 0; blk < 16; blk++) begin
        for (int i = 0; i < 4; i++) perm[i] = blk*4 + i;
        for (int i = 3; i > 0; i--) begin
          int j = int'($urandom_range(0, i));
          int t = perm[i]; perm[i] = perm[j]; perm[j] = t;
        end
        for (int i = 0; i < 4; ) begin
          int pat = int'($urandom_range(0, 3));
          if (pat == 0) begin
            step(0, 0, $urandom, $urandom, 0, 1, $urandom, $urandom);
          end else if (pat == 3 && i < 3) begin
            step(1, perm[i], p_pc[perm[i]], p_npc[perm[i]],
                 1, perm[i+1], p_pc[perm[i+1]], p_npc[perm[i+1]]);
            i += 2;
          end else if (pat == 2) begin
            step(0, perm[i], $urandom, $urandom, 1, perm[i], p_pc[perm[i]], p_npc[perm[i]]);
            i += 1;
          end else begin
            step(1, perm[i], p_pc[perm[i]], p_npc[perm[i]], 0, 3, $urandom, $urandom);
            i += 1;
          end
          chk("R2 R3 R4 random err", AW'(err), AW'(x_err));
        end
      end
      chk_all("R8 random record");
      if (bad < 0) chk("R5 random clean", AW'(err), '0);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule